// File: doc/BRIEF.md
# Compact shift/add/move/compare instruction decoder

This block decodes one 16-bit instruction from the compact encoding group whose two top bits are zero. That group holds the immediate shifts, the three-operand add and subtract, and the move, compare, add and subtract forms that take an 8-bit immediate. Each instruction becomes one micro-operation record. The record holds the ALU operation, the destination index and the first operand index, the second operand (a register or a zero-extended immediate), the shifter setting, a flag-update enable, a write-back enable and a valid bit.

Register indices are five bits wide. Architectural registers use indices 0 to 15, and index 16 is a hardwired zero register. An immediate shift becomes a move whose operand passes through the shifter, with the zero register as its first operand. The 8-bit-immediate forms read and write the same 3-bit register field.

A single output register with a valid/ready handshake sits behind the decoder. An upstream stage offers one instruction per cycle and a downstream stage drains one record per cycle. An encoding outside the group is taken and dropped, so no record leaves for it.

Top module: `narrow_alu_decode`

## Requirements
- R1: An accepted instruction whose bits 15:14 are 00 produces a record with out_valid high. An accepted instruction with any other value in bits 15:14 leaves out_valid low in the next cycle.
- R2: For bits 13:11 = 000, 001 or 010 the record is op MOV (0) with shift type 0, 1 or 2 (LSL, LSR, ASR). The shift amount is bits 10:6, src2 is bits 5:3, dst is bits 2:0 and src1 is the zero index 16. use_imm and imm are 0.
- R3: For bits 13:11 = 011 with bit 10 = 0, bit 9 picks ADD (1) or SUB (2). dst is bits 2:0, src1 is bits 5:3 and src2 is bits 8:6. The shift is LSL (0) by 0, and use_imm and imm are 0.
- R4: For bits 13:11 = 011 with bit 10 = 1, bit 9 picks ADD or SUB, and imm is bits 8:6 zero-extended with use_imm = 1. dst is bits 2:0, src1 is bits 5:3, and src2, the shift type and the shift amount are 0.
- R5: For bits 13:11 = 100 the record is MOV with dst = bits 10:8, src1 = 16 and imm = bits 7:0 with use_imm = 1.
- R6: For bits 13:11 = 101 the record is CMP (3) with dst = 16, src1 = bits 10:8 and imm = bits 7:0 with use_imm = 1. The flag update is on and write-back is off.
- R7: For bits 13:11 = 110 the record is ADD and for 111 it is SUB. Both use dst = src1 = bits 10:8 and imm = bits 7:0 with use_imm = 1.
- R8: Every valid record other than CMP has write-back on and the flag update off.
- R9: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, the record holds unchanged.
- R10: A new record loads only on a cycle where in_valid and in_ready are both high. A presented record taken with nothing behind it clears out_valid.
- R11: Reset (rst_n low, active low, synchronous) clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Stage can take an instruction |
| in_insn | input | 16 | Instruction word |
| out_ready | input | 1 | Downstream takes the record |
| out_valid | output | 1 | Record present |
| out_op | output | 2 | 0 MOV, 1 ADD, 2 SUB, 3 CMP |
| out_dst | output | 5 | Destination index (16 = zero register) |
| out_src1 | output | 5 | First operand index (16 = zero register) |
| out_src2 | output | 5 | Second operand register index |
| out_imm | output | 8 | Zero-extended immediate |
| out_use_imm | output | 1 | Second operand is the immediate |
| out_shtype | output | 2 | 0 LSL, 1 LSR, 2 ASR |
| out_shamt | output | 5 | Shift amount |
| out_setflags | output | 1 | Update condition flags |
| out_wb | output | 1 | Write result to dst |

## Verification
Two events can land on the same clock edge: the current record being taken by out_ready and the next instruction being loaded. The full sweep causes this on every cycle by keeping in_valid and out_ready high. Each cycle's record must then match the bench model for the instruction offered in the cycle before, with no repeated or lost record. Separate steps stall out_ready while a new instruction waits, check that the held record and in_ready stay fixed, and then release the stall so that release and load happen together.

// File: rtl/nad_pkg.sv
package nad_pkg;
    localparam int INSN_W   = 16;
    localparam int IDX_W    = 5;
    localparam int IMM_W    = 8;
    localparam int SHAMT_W  = 5;
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(1 << (IDX_W - 1));

    typedef enum logic [1:0] {
        OP_MOV = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2,
        OP_CMP = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef struct packed {
        logic                valid;
        alu_op_e             op;
        logic [IDX_W-1:0]    dst;
        logic [IDX_W-1:0]    src1;
        logic [IDX_W-1:0]    src2;
        logic [IMM_W-1:0]    imm;
        logic                use_imm;
        shift_e              shtype;
        logic [SHAMT_W-1:0]  shamt;
        logic                setflags;
        logic                wb;
    } uop_t;
endpackage

// File: rtl/nad_decode.sv
module nad_decode
    import nad_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output uop_t              uop
);
    logic [2:0] grp_code;
    logic [2:0] f_lo;
    logic [2:0] f_mid;
    logic [2:0] f_hi;
    logic [2:0] f_top;

    assign grp_code = insn[13:11];
    assign f_lo     = insn[2:0];
    assign f_mid    = insn[5:3];
    assign f_hi     = insn[8:6];
    assign f_top    = insn[10:8];

    always_comb begin
        uop       = '0;
        uop.valid = (insn[15:14] == 2'b00);
        case (grp_code)
            3'b000, 3'b001, 3'b010: begin
                uop.op     = OP_MOV;
                uop.dst    = IDX_W'(f_lo);
                uop.src1   = ZERO_IDX;
                uop.src2   = IDX_W'(f_mid);
                uop.shtype = shift_e'(grp_code[1:0]);
                uop.shamt  = insn[10:6];
                uop.wb     = 1'b1;
            end
            3'b011: begin
                uop.op   = insn[9] ? OP_SUB : OP_ADD;
                uop.dst  = IDX_W'(f_lo);
                uop.src1 = IDX_W'(f_mid);
                uop.wb   = 1'b1;
                if (insn[10]) begin
                    uop.use_imm = 1'b1;
                    uop.imm     = IMM_W'(f_hi);
                end else begin
                    uop.src2 = IDX_W'(f_hi);
                end
            end
            3'b100: begin
                uop.op      = OP_MOV;
                uop.dst     = IDX_W'(f_top);
                uop.src1    = ZERO_IDX;
                uop.imm     = insn[7:0];
                uop.use_imm = 1'b1;
                uop.wb      = 1'b1;
            end
            3'b101: begin
                uop.op       = OP_CMP;
                uop.dst      = ZERO_IDX;
                uop.src1     = IDX_W'(f_top);
                uop.imm      = insn[7:0];
                uop.use_imm  = 1'b1;
                uop.setflags = 1'b1;
            end
            default: begin
                uop.op      = insn[11] ? OP_SUB : OP_ADD;
                uop.dst     = IDX_W'(f_top);
                uop.src1    = IDX_W'(f_top);
                uop.imm     = insn[7:0];
                uop.use_imm = 1'b1;
                uop.wb      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/nad_stage.sv
module nad_stage
    import nad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  uop_t in_uop,
    input  logic out_ready,
    output uop_t out_uop
);
    uop_t stage_d;
    uop_t stage_q;
    logic take_d;

    assign in_ready = !stage_q.valid || out_ready;
    assign take_d   = in_valid && in_ready;
    assign out_uop  = stage_q;

    always_comb begin
        stage_d = stage_q;
        if (stage_q.valid && out_ready) begin
            stage_d.valid = 1'b0;
        end
        if (take_d) begin
            stage_d = in_uop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && !out_ready) |=> (stage_q.valid && $stable(stage_q)));

    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && out_ready && !in_valid) |=> !stage_q.valid);

    p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_uop.valid) |=> !stage_q.valid);
endmodule

// File: rtl/narrow_alu_decode.sv
module narrow_alu_decode
    import nad_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [15:0]        in_insn,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [1:0]         out_op,
    output logic [4:0]         out_dst,
    output logic [4:0]         out_src1,
    output logic [4:0]         out_src2,
    output logic [7:0]         out_imm,
    output logic               out_use_imm,
    output logic [1:0]         out_shtype,
    output logic [4:0]         out_shamt,
    output logic               out_setflags,
    output logic               out_wb
);
    uop_t dec_uop;
    uop_t reg_uop;

    nad_decode i_decode (
        .insn (in_insn),
        .uop  (dec_uop)
    );

    nad_stage i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_uop    (dec_uop),
        .out_ready (out_ready),
        .out_uop   (reg_uop)
    );

    assign out_valid    = reg_uop.valid;
    assign out_op       = reg_uop.op;
    assign out_dst      = reg_uop.dst;
    assign out_src1     = reg_uop.src1;
    assign out_src2     = reg_uop.src2;
    assign out_imm      = reg_uop.imm;
    assign out_use_imm  = reg_uop.use_imm;
    assign out_shtype   = reg_uop.shtype;
    assign out_shamt    = reg_uop.shamt;
    assign out_setflags = reg_uop.setflags;
    assign out_wb       = reg_uop.wb;

    p_cmp_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op == 2'd3) |-> (!out_wb && out_setflags && out_dst == ZERO_IDX));

    p_flag_xor_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wb != out_setflags));

    p_mov_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op == 2'd0) |-> (out_src1 == ZERO_IDX));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_insn[15:14] == 2'b00) |=> out_valid);
endmodule

// File: tb/test_narrow_alu_decode.sv
module test_narrow_alu_decode;
    localparam int CLK_PERIOD = 10;
    localparam int ZR = 16;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_insn;
    logic        out_ready;
    logic        out_valid;
    logic [1:0]  out_op;
    logic [4:0]  out_dst;
    logic [4:0]  out_src1;
    logic [4:0]  out_src2;
    logic [7:0]  out_imm;
    logic        out_use_imm;
    logic [1:0]  out_shtype;
    logic [4:0]  out_shamt;
    logic        out_setflags;
    logic        out_wb;

    int n_checks = 0;
    int n_fail   = 0;

    narrow_alu_decode i_narrow_alu_decode (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .out_ready(out_ready), .out_valid(out_valid),
        .out_op(out_op), .out_dst(out_dst), .out_src1(out_src1),
        .out_src2(out_src2), .out_imm(out_imm), .out_use_imm(out_use_imm),
        .out_shtype(out_shtype), .out_shamt(out_shamt),
        .out_setflags(out_setflags), .out_wb(out_wb)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [34:0] got_rec();
        return {out_op, out_dst, out_src1, out_src2, out_imm, out_use_imm,
                out_shtype, out_shamt, out_setflags, out_wb};
    endfunction

    function automatic logic [34:0] model(input logic [15:0] w);
        int op, dst, s1, s2, imm, ui, sh, amt, sf, wb;
        int c;
        c = int'(w[13:11]);
        op = 0; dst = 0; s1 = 0; s2 = 0; imm = 0; ui = 0; sh = 0; amt = 0; sf = 0; wb = 1;
        if (c <= 2) begin
            dst = int'(w[2:0]); s1 = ZR; s2 = int'(w[5:3]); sh = c; amt = int'(w[10:6]);
        end else if (c == 3) begin
            op = 1 + int'(w[9]); dst = int'(w[2:0]); s1 = int'(w[5:3]);
            if (w[10]) begin imm = int'(w[8:6]); ui = 1; end
            else s2 = int'(w[8:6]);
        end else if (c == 4) begin
            dst = int'(w[10:8]); s1 = ZR; imm = int'(w[7:0]); ui = 1;
        end else if (c == 5) begin
            op = 3; dst = ZR; s1 = int'(w[10:8]); imm = int'(w[7:0]); ui = 1; sf = 1; wb = 0;
        end else begin
            op = (c == 6) ? 1 : 2; dst = int'(w[10:8]); s1 = dst; imm = int'(w[7:0]); ui = 1;
        end
        return {2'(op), 5'(dst), 5'(s1), 5'(s2), 8'(imm), 1'(ui), 2'(sh), 5'(amt), 1'(sf), 1'(wb)};
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        if (w[15:14] != 2'b00) return "R1";
        case (w[13:11])
            3'd0, 3'd1, 3'd2: return "R2";
            3'd3:             return w[10] ? "R4" : "R3";
            3'd4:             return "R5";
            3'd5:             return "R6";
            default:          return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [34:0] got, input logic [34:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic offer(input logic [15:0] w, input logic v);
        @(negedge clk);
        in_insn  = w;
        in_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_rec(input logic [15:0] w, input string what);
        check(tag_of(w), what, {34'd0, out_valid}, 35'd1);
        check(tag_of(w), what, got_rec(), model(w));
        check("R8", "wb vs flags", {33'd0, out_wb, out_setflags},
              {33'd0, (w[13:11] != 3'd5), (w[13:11] == 3'd5)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset valid", {34'd0, out_valid}, 35'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1-style exhaustive sweep: every word, back-to-back, drain and load each edge
        for (int i = 0; i < 65536; i++) begin
            offer(16'(i), 1'b1);
            if (i[15:14] == 2'b00) expect_rec(16'(i), "sweep");
            else check("R1", "outside group", {34'd0, out_valid}, 35'd0);
        end

        // R10: taken record with nothing behind clears valid
        offer(16'h1C8A, 1'b1);
        expect_rec(16'h1C8A, "pre-drain");
        offer(16'h0000, 1'b0);
        check("R10", "drain", {34'd0, out_valid}, 35'd0);

        // R9: stall holds record, blocks input
        offer(16'h2345, 1'b1);
        expect_rec(16'h2345, "before stall");
        @(negedge clk);
        out_ready = 1'b0;
        in_insn   = 16'h2D10;
        in_valid  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            check("R9", "in_ready stalled", {34'd0, in_ready}, 35'd0);
            check("R9", "held record", got_rec(), model(16'h2345));
        end
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check("R9", "in_ready released", {34'd0, in_ready}, 35'd1);
        @(posedge clk);
        #1;
        expect_rec(16'h2D10, "R10 load on release");

        // R9: empty stage accepts even with out_ready low
        offer(16'h0000, 1'b0);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check("R9", "bubble in_ready", {34'd0, in_ready}, 35'd1);
        offer(16'h3EFF, 1'b1);
        expect_rec(16'h3EFF, "bubble load");
        offer(16'hC123, 1'b1);
        check("R9", "invalid blocked while held", got_rec(), model(16'h3EFF));

        // R11: reset while a record is held
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R11", "reset mid-run", {34'd0, out_valid}, 35'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule